// File: doc/BRIEF.md
# Four-Lane Packed Element Permute Unit

This block rearranges 32-bit elements inside 128-bit vectors. It takes a first operand (A), a second operand (B), a 3-bit operation code and an 8-bit immediate. It returns one registered 128-bit result together with a valid pulse. The element contents are opaque: the block only moves whole 32-bit lanes and never looks inside them.

Five operations are supported:

- an immediate-controlled shuffle, in which the two lower result lanes come from A and the two upper result lanes come from B;
- low interleave;
- high interleave;
- a move of B's upper half into the lower half of A;
- a move of B's lower half into the upper half of A.

A caller presents the operands with `start` high for one cycle. The result appears on the next clock edge. Broadcast, reversal and rotation of a single vector are done with the shuffle, by feeding the same vector to both operands.

Top module: `vperm_unit`

## Requirements
- R1: Lane k of a 128-bit vector occupies bits [32k+31:32k]. In shuffle mode (op = 0), result lane 0 is A lane imm[1:0] and result lane 1 is A lane imm[3:2].
- R2: In shuffle mode, result lane 2 is B lane imm[5:4] and result lane 3 is B lane imm[7:6].
- R3: With A equal to B, the shuffle gives these results: immediates 00h, 55h, AAh and FFh broadcast lane 0, 1, 2 and 3; 1Bh reverses the lane order; 93h moves lane 3 to lane 0 and shifts the others up; 39h moves lane 0 to lane 3 and shifts the others down.
- R4: Low interleave (op = 1) returns {B1, A1, B0, A0}, written from lane 3 down to lane 0.
- R5: High interleave (op = 2) returns {B3, A3, B2, A2}.
- R6: High-to-low move (op = 3) returns {A3, A2, B3, B2}.
- R7: Low-to-high move (op = 4) returns {B1, B0, A1, A0}.
- R8: The immediate has no effect for op = 1 to 4. Op codes 5, 6 and 7 return A unchanged.
- R9: The result and `result_vld` update on the clock edge at which `start` is sampled high. `result_vld` is high for exactly the cycle after each start cycle.
- R10: While `start` is low, the result holds its last value and `result_vld` is low.
- R11: A synchronous active-low reset clears the result to zero and drops `result_vld`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Launch one operation on the current inputs |
| op | input | 3 | Operation code: 0 shuffle, 1 low interleave, 2 high interleave, 3 high-to-low move, 4 low-to-high move |
| imm | input | 8 | Four 2-bit lane selectors for the shuffle |
| src_a | input | 128 | First operand |
| src_b | input | 128 | Second operand |
| result | output | 128 | Registered permuted vector |
| result_vld | output | 1 | One-cycle pulse marking a fresh result |

## Verification
Every lane carries a distinct tag value, so a wrong selector decode or a swapped mode path shows at the ports as a foreign tag in a specific lane. This is visible one cycle after the start strobe. A mistake in the result register's enable shows in the idle cycle after a pulse, as either a changed result or a stretched valid. A reset fault shows as nonzero data on the first edge after reset is asserted. The directed table covers every operation, plus immediates that reach all four selector codes in every lane.

// File: rtl/vperm_pkg.sv
// Shared types and constants for the packed element permute unit.
// Assumes four 32-bit lanes per 128-bit vector, with lane 0 in the low bits.
package vperm_pkg;
    localparam int LANE_W  = 32;
    localparam int LANES   = 4;
    localparam int VEC_W   = LANE_W * LANES;
    localparam int SEL_W   = $clog2(LANES);
    localparam int IMM_W   = SEL_W * LANES;
    localparam int OP_W    = 3;

    typedef logic [LANE_W-1:0] lane_t;
    typedef logic [VEC_W-1:0]  vec_t;

    typedef enum logic [OP_W-1:0] {
        OP_SHUF = 3'd0,
        OP_ILO  = 3'd1,
        OP_IHI  = 3'd2,
        OP_HTOL = 3'd3,
        OP_LTOH = 3'd4
    } perm_op_e;
endpackage

// File: rtl/vperm_lane_sel.sv
// Picks one 32-bit lane out of a four-lane vector by a 2-bit index.
// Purely combinational; the index is always in range.
module vperm_lane_sel
    import vperm_pkg::*;
(
    input  vec_t             vec,
    input  logic [SEL_W-1:0] idx,
    output lane_t            lane
);
    // Indexed part-select of the chosen lane.
    always_comb begin
        lane = vec[idx*LANE_W +: LANE_W];
    end
endmodule

// File: rtl/vperm_core.sv
// Combinational permute datapath. It builds the shuffle result from per-lane
// selectors, then picks among the shuffle, interleave and half-move patterns
// by operation code. Unknown codes pass operand A through untouched.
module vperm_core
    import vperm_pkg::*;
(
    input  logic [OP_W-1:0]  op,
    input  logic [IMM_W-1:0] imm,
    input  vec_t             a,
    input  vec_t             b,
    output vec_t             y
);
    localparam int HALF = LANES / 2;

    lane_t al [LANES];
    lane_t bl [LANES];
    lane_t sh [LANES];

    // One selector per result lane: the lower half draws from A, the upper half from B.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign al[i] = a[i*LANE_W +: LANE_W];
        assign bl[i] = b[i*LANE_W +: LANE_W];
        if (i < HALF) begin : g_from_a
            vperm_lane_sel u_sel (.vec(a), .idx(imm[i*SEL_W +: SEL_W]), .lane(sh[i]));
        end else begin : g_from_b
            vperm_lane_sel u_sel (.vec(b), .idx(imm[i*SEL_W +: SEL_W]), .lane(sh[i]));
        end
    end

    // Mode multiplexer that assembles the output vector.
    always_comb begin
        unique case (op)
            OP_SHUF: y = {sh[3], sh[2], sh[1], sh[0]};
            OP_ILO:  y = {bl[1], al[1], bl[0], al[0]};
            OP_IHI:  y = {bl[3], al[3], bl[2], al[2]};
            OP_HTOL: y = {al[3], al[2], bl[3], bl[2]};
            OP_LTOH: y = {bl[1], bl[0], al[1], al[0]};
            default: y = a;
        endcase
    end
endmodule

// File: rtl/vperm_unit.sv
// Top of the packed element permute unit. It registers the core's result
// when start is high and emits a one-cycle valid pulse. Synchronous active-low reset.
module vperm_unit
    import vperm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [OP_W-1:0]   op,
    input  logic [IMM_W-1:0]  imm,
    input  logic [VEC_W-1:0]  src_a,
    input  logic [VEC_W-1:0]  src_b,
    output logic [VEC_W-1:0]  result,
    output logic              result_vld
);
    vec_t perm_y;

    vperm_core u_core (
        .op  (op),
        .imm (imm),
        .a   (src_a),
        .b   (src_b),
        .y   (perm_y)
    );

    // Capture the permuted vector on start and hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)     result <= '0;
        else if (start) result <= perm_y;
    end

    // One-cycle valid pulse following each start.
    always_ff @(posedge clk) begin
        if (!rst_n) result_vld <= 1'b0;
        else        result_vld <= start;
    end
endmodule

// File: rtl/vperm_unit_chk.sv
// Property checker for vperm_unit, bound to every instance of the top module.
module vperm_unit_chk
    import vperm_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [OP_W-1:0]   op,
    input logic [IMM_W-1:0]  imm,
    input logic [VEC_W-1:0]  src_a,
    input logic [VEC_W-1:0]  src_b,
    input logic [VEC_W-1:0]  result,
    input logic              result_vld
);
    lane_t pick_a0, pick_b3;
    logic  rst_q = 1'b0;

    // Reference lane picks for the shuffle properties.
    always_comb begin
        pick_a0 = src_a[imm[1:0]*LANE_W +: LANE_W];
        pick_b3 = src_b[imm[7:6]*LANE_W +: LANE_W];
    end

    assert_shuf_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op == OP_SHUF) |=> result[31:0] == $past(pick_a0));

    assert_shuf_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op == OP_SHUF) |=> result[127:96] == $past(pick_b3));

    assert_ilo_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op == OP_ILO) |=> result == $past({src_b[63:32], src_a[63:32], src_b[31:0], src_a[31:0]}));

    assert_htol_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op == OP_HTOL) |=> result == $past({src_a[127:64], src_b[127:64]}));

    assert_vld_on_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> result_vld);

    assert_vld_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !result_vld);

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> $stable(result));

    // After a reset edge, the outputs must already be clear.
    always @(posedge clk) begin
        if (rst_q) assert_reset_clear_R11: assert (result == '0 && !result_vld);
        rst_q <= !rst_n;
    end
endmodule

bind vperm_unit vperm_unit_chk u_chk (.*);

// File: tb/sim_vperm_unit.sv
// Self-checking bench: a table of permute vectors, then directed tests.
module sim_vperm_unit;
    localparam int PERIOD = 10;
    localparam int NV = 14;

    localparam logic [31:0] A0 = 32'hAAAA_0000, A1 = 32'hAAAA_0001, A2 = 32'hAAAA_0002, A3 = 32'hAAAA_0003;
    localparam logic [31:0] B0 = 32'hBBBB_0000, B1 = 32'hBBBB_0001, B2 = 32'hBBBB_0002, B3 = 32'hBBBB_0003;
    localparam logic [127:0] VA = {A3, A2, A1, A0};
    localparam logic [127:0] VB = {B3, B2, B1, B0};

    // Columns: op, imm, B equals A, expected result, requirement tag.
    localparam logic [2:0] T_OP  [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 2, 3, 4, 7};
    localparam logic [7:0] T_IMM [NV] = '{8'h00, 8'h55, 8'hAA, 8'hFF, 8'h1B, 8'h93, 8'h39,
                                          8'hE4, 8'h4E, 8'hFF, 8'h5A, 8'hFF, 8'h1B, 8'h4E};
    localparam logic       T_EQ  [NV] = '{1, 1, 1, 1, 1, 1, 1, 0, 0, 0, 0, 0, 0, 0};
    localparam logic [127:0] T_EXP [NV] = '{
        {A0, A0, A0, A0},   // R3 broadcast lane 0
        {A1, A1, A1, A1},   // R3 broadcast lane 1
        {A2, A2, A2, A2},   // R3 broadcast lane 2
        {A3, A3, A3, A3},   // R3 broadcast lane 3
        {A0, A1, A2, A3},   // R3 reverse
        {A2, A1, A0, A3},   // R3 rotate top to lane 0
        {A0, A3, A2, A1},   // R3 rotate lane 0 to top
        {B3, B2, A1, A0},   // R1 R2 identity selectors
        {B1, B0, A3, A2},   // R1 R2 crossed selectors
        {B1, A1, B0, A0},   // R4 low interleave, R8 imm ignored
        {B3, A3, B2, A2},   // R5 high interleave
        {A3, A2, B3, B2},   // R6 high to low
        {B1, B0, A1, A0},   // R7 low to high
        {A3, A2, A1, A0}    // R8 reserved code passes A
    };
    localparam int T_REQ [NV] = '{3, 3, 3, 3, 3, 3, 3, 1, 2, 4, 5, 6, 7, 8};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [2:0]   op = '0;
    logic [7:0]   imm = '0;
    logic [127:0] src_a = '0, src_b = '0;
    logic [127:0] result;
    logic         result_vld;
    int checks = 0;
    int errors = 0;

    always #(PERIOD/2) clk = ~clk;

    vperm_unit u0 (.clk(clk), .rst_n(rst_n), .start(start), .op(op), .imm(imm),
                   .src_a(src_a), .src_b(src_b), .result(result), .result_vld(result_vld));

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Drive one start cycle; returns at the following negedge with the result visible.
    task automatic launch(input logic [2:0] o, input logic [7:0] im, input logic [127:0] a, input logic [127:0] b);
        @(negedge clk);
        op = o; imm = im; src_a = a; src_b = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    initial begin
        #(PERIOD * 20000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [127:0] last;
        // R11: reset state
        repeat (2) @(negedge clk);
        check("R11 reset result", result, '0);
        check("R11 reset vld", {127'd0, result_vld}, 128'd0);
        rst_n = 1'b1;

        // Table walk: R1-related vectors and the rest, each followed by an idle-cycle check.
        for (int i = 0; i < NV; i++) begin
            launch(T_OP[i], T_IMM[i], VA, T_EQ[i] ? VA : VB);
            check($sformatf("R%0d vector %0d", T_REQ[i], i), result, T_EXP[i]);
            check("R9 vld pulse", {127'd0, result_vld}, 128'd1);
            src_a = ~VA; src_b = ~VB; imm = ~imm;
            @(negedge clk);
            check("R10 hold", result, T_EXP[i]);
            check("R10 vld low", {127'd0, result_vld}, 128'd0);
        end

        // R8: imm ignored for interleave; compare two immediates.
        launch(3'd1, 8'h00, VA, VB);
        check("R8 imm 00 low interleave", result, {B1, A1, B0, A0});
        // Reserved codes 5 and 6 pass A.
        launch(3'd5, 8'h1B, VA, VB);
        check("R8 op5 passes A", result, VA);
        launch(3'd6, 8'hE4, VA, VB);
        check("R8 op6 passes A", result, VA);

        // R9: back-to-back starts keep vld high and update each cycle.
        @(negedge clk);
        op = 3'd2; imm = 8'h00; src_a = VA; src_b = VB; start = 1'b1;
        @(negedge clk);
        check("R5 back-to-back first", result, {B3, A3, B2, A2});
        check("R9 vld first", {127'd0, result_vld}, 128'd1);
        op = 3'd3;
        @(negedge clk);
        start = 1'b0;
        check("R6 back-to-back second", result, {A3, A2, B3, B2});
        check("R9 vld second", {127'd0, result_vld}, 128'd1);
        @(negedge clk);
        check("R9 vld drops", {127'd0, result_vld}, 128'd0);
        last = result;
        repeat (3) @(negedge clk);
        check("R10 long hold", result, last);

        // R11: reset while start is high clears outputs.
        op = 3'd0; imm = 8'hE4; start = 1'b1; rst_n = 1'b0;
        @(negedge clk);
        start = 1'b0;
        check("R11 reset beats start", result, '0);
        check("R11 reset vld", {127'd0, result_vld}, 128'd0);
        rst_n = 1'b1;
        launch(3'd0, 8'hE4, VA, VB);
        check("R1 after reset", result, {B3, B2, A1, A0});
        finish_run();
    end
endmodule